// File: doc/BRIEF.md
# Parallel-Port IDE Register Sequencer

This block sits on the host side of a parallel-port link to an IDE bridge. It reads or writes one IDE register per request by driving the port's data and control lines through a fixed list of steps. The list depends on the transfer mode and on the direction. A request carries five things: a register index, a bit that picks the control register set or the task-file set, a write value, a 3-bit mode and a per-step hold count. The block computes the encoded address byte, runs the steps for the chosen mode and direction, samples the port inputs at the right steps and returns the read byte with a one-cycle done strobe.

Modes 0 to 2 are narrow modes. In these the address byte is sent on the data lines and framed by control-line writes. Modes 0 and 1 rebuild the read byte from split samples of the status lines. Mode 2 takes the byte from the data lines. Modes 3 to 5 use the enhanced-parallel-port handshake: an address phase on an address strobe, then a data phase on a data strobe. A mode value of 6 or 7 is rejected at once with an error flag.

Every step that the sequencer runs, whether it drives a line, pulses a strobe or takes a sample, lasts `hold + 1` clock cycles. This gives slow peripherals room to meet their setup time. The control lines rest at 0x04 and the data lines at 0x00.

Top module: `ppide_reg_seq`

## Requirements
- R1: The 8-bit bus address is the register index when `ctl_sel` is 0, and the register index plus 0x80 when `ctl_sel` is 1. Mode encodings are applied to this address.
- R2: A mode-0 read puts address XOR 0x39 on `pd_out`, then writes control values 0x01, 0x03, 0x01, 0x04. The first status sample is taken after 0x03 and the second after the later 0x01. The result is {second[7:4], first[7:4]}.
- R3: A mode-1 read puts r = address XOR 0x31 on `pd_out`, then r AND 0x37, then r OR 0xF0. The control values are 0x01, 0x03, 0x05, 0x04. The result is {`aux_in`[3:1], `stat_in`[7:3]}, sampled after the last data value.
- R4: A mode-2 read puts address XOR 0x29 on `pd_out`, writes control values 0x01, 0x21, 0x23, 0x04 and returns `pd_in` as sampled after 0x23. Whenever `pc_out` bit 5 is set, `pd_oe` is low.
- R5: A write in modes 0 to 2 puts address XOR 0x19 on `pd_out` and then the write value. The control values are 0x01, 0x03, 0x04, with 0x01 written between the address and the value.
- R6: A read in modes 3 to 5 presents the unencoded address on `pd_out` with `epp_astb` high and `epp_wr` high. It then writes control value 0x24, raises `epp_dstb` with `epp_wr` low and returns `pd_in`, then writes control value 0x04.
- R7: A write in modes 3 to 5 presents address XOR 0x40 with `epp_astb`, then exactly one data phase carrying the write value with `epp_dstb` and `epp_wr` high. The control lines do not change. `epp_astb` and `epp_dstb` are never high together.
- R8: Each step lasts `hold`+1 cycles. `done` goes high (steps × (hold+1) + 1) cycles after the clock edge that accepts `start`.
- R9: Mode 6 or 7 raises `done` and `err` together on the second edge after acceptance, with `rd_data` = 0xFF. No port line changes. `err` is never high without `done`.
- R10: `done` is a one-cycle pulse. A `start` seen while `busy` is high is ignored.
- R11: After reset, `pc_out` = 0x04, `pd_out` = 0x00, both strobes are low, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, taken when not busy |
| is_write | input | 1 | 1 = register write, 0 = register read |
| ctl_sel | input | 1 | 1 = control register set, 0 = task-file set |
| reg_idx | input | IDX_W | Register index |
| mode | input | 3 | Transfer mode 0..5 |
| wr_val | input | 8 | Value for a write |
| hold | input | HOLD_W | Extra cycles each step is held |
| stat_in | input | 8 | Status lines of the port |
| aux_in | input | 8 | Control-port readback lines |
| pd_in | input | 8 | Data lines as read |
| pd_out | output | 8 | Data lines as driven |
| pd_oe | output | 1 | Data line driver enable |
| pc_out | output | 8 | Control lines as driven |
| epp_astb | output | 1 | Address-phase strobe |
| epp_dstb | output | 1 | Data-phase strobe |
| epp_wr | output | 1 | Phase direction, 1 = host writes |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Completion with an invalid mode |
| rd_data | output | 8 | Read result, valid with done |

## Verification
The bench uses a model peripheral whose status and readback lines hold junk bits next to the payload bits. A wrong shift or mask in the 4+4 or 5+3 rebuild therefore returns a wrong byte, and a swap of the two nibble samples shows up as a byte with its halves exchanged. The bench logs every change on the control and data lines and every strobe phase. A wrong XOR key, a missing 0x80 offset, a lost intermediate data value or an extra EPP data phase each leaves a log that differs from the expected one. The bench also counts cycles to `done` at two hold values, which catches an off-by-one step hold. It starts an invalid-mode request in the middle of a transfer; if that request is not ignored, the running write is corrupted or a second `done` appears.

// File: rtl/ppide_pkg.sv
// Shared types and constants for the parallel-port IDE register sequencer.
// Assumes 8-bit port lanes; the step list encoding is private to this block.
package ppide_pkg;

    typedef enum logic [2:0] {
        OP_DATA,   // drive data lines
        OP_CTRL,   // drive control lines
        OP_ADDR,   // enhanced address phase
        OP_WDAT,   // enhanced data phase, host writes
        OP_RDAT,   // enhanced data phase, host reads
        OP_SMPA,   // take status, readback and data samples
        OP_SMPB,   // take second status sample
        OP_END     // finish, report
    } op_e;

    typedef struct packed {
        op_e        op;
        logic [7:0] val;
    } step_t;

    localparam logic [7:0] KEY_RD_NIB   = 8'h39;
    localparam logic [7:0] KEY_RD_53    = 8'h31;
    localparam logic [7:0] KEY_RD_BYTE  = 8'h29;
    localparam logic [7:0] KEY_WR_NAR   = 8'h19;
    localparam logic [7:0] KEY_WR_EPP   = 8'h40;
    localparam logic [7:0] CTL_SET_OFS  = 8'h80;
    localparam logic [7:0] CTL_IDLE     = 8'h04;
    localparam logic [2:0] MODE_TOP     = 3'd5;

endpackage

// File: rtl/ppide_step_rom.sv
// Step list decoder: returns the step at a given index for a mode/direction.
// Assumes indices past the end of a list decode as OP_END; modes 6/7 are OP_END at index 0.
module ppide_step_rom
    import ppide_pkg::*;
#(
    parameter int STEP_W = 4
) (
    input  logic [2:0]        mode,
    input  logic              is_write,
    input  logic [7:0]        addr,
    input  logic [7:0]        wval,
    input  logic [STEP_W-1:0] idx,
    output step_t             step
);

    logic [7:0] r53;
    int         i;

    // Pick the step for the current mode, direction and index.
    always_comb begin
        step = '{OP_END, 8'h00};
        r53  = addr ^ KEY_RD_53;
        i    = int'(idx);
        if (!is_write) begin
            case (mode)
                3'd0: case (i)
                    0: step = '{OP_DATA, addr ^ KEY_RD_NIB};
                    1: step = '{OP_CTRL, 8'h01};
                    2: step = '{OP_CTRL, 8'h03};
                    3: step = '{OP_SMPA, 8'h00};
                    4: step = '{OP_CTRL, 8'h01};
                    5: step = '{OP_SMPB, 8'h00};
                    6: step = '{OP_CTRL, CTL_IDLE};
                    default: ;
                endcase
                3'd1: case (i)
                    0: step = '{OP_DATA, r53};
                    1: step = '{OP_CTRL, 8'h01};
                    2: step = '{OP_DATA, r53 & 8'h37};
                    3: step = '{OP_CTRL, 8'h03};
                    4: step = '{OP_CTRL, 8'h05};
                    5: step = '{OP_DATA, r53 | 8'hF0};
                    6: step = '{OP_SMPA, 8'h00};
                    7: step = '{OP_CTRL, CTL_IDLE};
                    default: ;
                endcase
                3'd2: case (i)
                    0: step = '{OP_DATA, addr ^ KEY_RD_BYTE};
                    1: step = '{OP_CTRL, 8'h01};
                    2: step = '{OP_CTRL, 8'h21};
                    3: step = '{OP_CTRL, 8'h23};
                    4: step = '{OP_SMPA, 8'h00};
                    5: step = '{OP_CTRL, CTL_IDLE};
                    default: ;
                endcase
                3'd3, 3'd4, 3'd5: case (i)
                    0: step = '{OP_ADDR, addr};
                    1: step = '{OP_CTRL, 8'h24};
                    2: step = '{OP_RDAT, 8'h00};
                    3: step = '{OP_CTRL, CTL_IDLE};
                    default: ;
                endcase
                default: ;
            endcase
        end else begin
            case (mode)
                3'd0, 3'd1, 3'd2: case (i)
                    0: step = '{OP_DATA, addr ^ KEY_WR_NAR};
                    1: step = '{OP_CTRL, 8'h01};
                    2: step = '{OP_DATA, wval};
                    3: step = '{OP_CTRL, 8'h03};
                    4: step = '{OP_CTRL, CTL_IDLE};
                    default: ;
                endcase
                3'd3, 3'd4, 3'd5: case (i)
                    0: step = '{OP_ADDR, addr ^ KEY_WR_EPP};
                    1: step = '{OP_WDAT, wval};
                    default: ;
                endcase
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ppide_assemble.sv
// Rebuilds a read byte from the port samples according to the mode.
// Assumes samples were captured by the sequencer at its sample steps.
module ppide_assemble (
    input  logic [2:0] mode,
    input  logic [7:0] smp_a,
    input  logic [7:0] smp_b,
    input  logic [7:0] smp_d,
    output logic [7:0] byte_o
);

    // Merge the split samples: 4+4 nibbles, 5+3 bits, or the whole data byte.
    always_comb begin
        case (mode)
            3'd0:    byte_o = {smp_b[7:4], smp_a[7:4]};
            3'd1:    byte_o = {smp_b[3:1], smp_a[7:3]};
            default: byte_o = smp_d;
        endcase
    end

endmodule

// File: rtl/ppide_reg_seq.sv
// Top of the register sequencer: accepts a request, walks the step list,
// drives the port lines, samples inputs and reports the read byte.
// Assumes port inputs are stable for the whole of a sample step.
module ppide_reg_seq
    import ppide_pkg::*;
#(
    parameter int IDX_W  = 7,
    parameter int HOLD_W = 8,
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_write,
    input  logic              ctl_sel,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [2:0]        mode,
    input  logic [7:0]        wr_val,
    input  logic [HOLD_W-1:0] hold,
    input  logic [7:0]        stat_in,
    input  logic [7:0]        aux_in,
    input  logic [7:0]        pd_in,
    output logic [7:0]        pd_out,
    output logic              pd_oe,
    output logic [7:0]        pc_out,
    output logic              epp_astb,
    output logic              epp_dstb,
    output logic              epp_wr,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [7:0]        rd_data
);

    localparam int PAD_W = 8 - IDX_W;

    logic              busy_q, wr_q;
    logic [2:0]        mode_q;
    logic [7:0]        addr_q, val_q, addr_in;
    logic [HOLD_W-1:0] hold_q, cnt_q;
    logic [STEP_W-1:0] idx_q, nxt_idx;
    logic [7:0]        smp_a, smp_b, smp_d, asm_byte;
    logic              accept, advance, bad_mode;
    logic [2:0]        n_mode;
    logic              n_wr;
    logic [7:0]        n_addr, n_val;
    step_t             cur, nxt;

    // Bus address: index widened, control set offset added.
    assign addr_in  = {{PAD_W{1'b0}}, reg_idx} + (ctl_sel ? CTL_SET_OFS : 8'h00);
    assign accept   = start && !busy_q;
    assign advance  = accept || (busy_q && cur.op != OP_END && cnt_q == hold_q);
    assign bad_mode = mode_q > MODE_TOP;

    // Parameters of the step about to be entered come from the request when idle.
    assign n_mode  = busy_q ? mode_q : mode;
    assign n_wr    = busy_q ? wr_q   : is_write;
    assign n_addr  = busy_q ? addr_q : addr_in;
    assign n_val   = busy_q ? val_q  : wr_val;
    assign nxt_idx = busy_q ? idx_q + 1'b1 : '0;

    ppide_step_rom #(.STEP_W(STEP_W)) u_rom_cur (
        .mode(mode_q), .is_write(wr_q), .addr(addr_q), .wval(val_q),
        .idx(idx_q), .step(cur)
    );

    ppide_step_rom #(.STEP_W(STEP_W)) u_rom_nxt (
        .mode(n_mode), .is_write(n_wr), .addr(n_addr), .wval(n_val),
        .idx(nxt_idx), .step(nxt)
    );

    ppide_assemble u_asm (
        .mode(mode_q), .smp_a(smp_a), .smp_b(smp_b), .smp_d(smp_d),
        .byte_o(asm_byte)
    );

    // Request latch, step index, hold counter and completion report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            wr_q    <= 1'b0;
            mode_q  <= '0;
            addr_q  <= '0;
            val_q   <= '0;
            hold_q  <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (accept) begin
                busy_q <= 1'b1;
                wr_q   <= is_write;
                mode_q <= mode;
                addr_q <= addr_in;
                val_q  <= wr_val;
                hold_q <= hold;
                cnt_q  <= '0;
                idx_q  <= '0;
            end else if (busy_q && cur.op == OP_END) begin
                busy_q  <= 1'b0;
                done    <= 1'b1;
                err     <= bad_mode;
                rd_data <= bad_mode ? 8'hFF : asm_byte;
            end else if (advance) begin
                idx_q <= nxt_idx;
                cnt_q <= '0;
            end else if (busy_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Sample capture on the edge that leaves a sample step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_a <= '0;
            smp_b <= '0;
            smp_d <= '0;
        end else if (busy_q && advance) begin
            case (cur.op)
                OP_SMPA: begin
                    smp_a <= stat_in;
                    smp_b <= aux_in;
                    smp_d <= pd_in;
                end
                OP_SMPB: smp_b <= stat_in;
                OP_RDAT: smp_d <= pd_in;
                default: ;
            endcase
        end
    end

    // Port line drive on the edge that enters a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_out   <= '0;
            pc_out   <= CTL_IDLE;
            epp_astb <= 1'b0;
            epp_dstb <= 1'b0;
            epp_wr   <= 1'b0;
        end else if (advance) begin
            epp_astb <= 1'b0;
            epp_dstb <= 1'b0;
            epp_wr   <= 1'b0;
            case (nxt.op)
                OP_DATA: pd_out <= nxt.val;
                OP_CTRL: pc_out <= nxt.val;
                OP_ADDR: begin
                    pd_out   <= nxt.val;
                    epp_astb <= 1'b1;
                    epp_wr   <= 1'b1;
                end
                OP_WDAT: begin
                    pd_out   <= nxt.val;
                    epp_dstb <= 1'b1;
                    epp_wr   <= 1'b1;
                end
                OP_RDAT: epp_dstb <= 1'b1;
                default: ;
            endcase
        end
    end

    // Release the data lines while the peripheral may drive them.
    assign pd_oe = !pc_out[5] && !(epp_dstb && !epp_wr);
    assign busy  = busy_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R9
    AST_BAD_MODE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode > MODE_TOP) |=> ##1 (done && err && rd_data == 8'hFF)); // R9
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(epp_astb && epp_dstb)); // R7
    AST_DRIVE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_out[5] |-> !pd_oe); // R4
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start) |=> ($stable(mode_q) && $stable(addr_q))); // R10
    AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> cnt_q <= hold_q); // R8

endmodule

// File: tb/tb_ppide_reg_seq.sv
module tb_ppide_reg_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, is_write = 1'b0, ctl_sel = 1'b0;
    logic [6:0] reg_idx = '0;
    logic [2:0] mode = '0;
    logic [7:0] wr_val = '0, hold = '0;
    logic [7:0] stat_in, aux_in, pd_in;
    logic [7:0] pd_out, pc_out, rd_data;
    logic       pd_oe, epp_astb, epp_dstb, epp_wr, busy, done, err;

    int total = 0, fails = 0;
    int resp_kind = 0;
    logic [7:0] resp_byte = '0;

    logic [7:0] clog [16], dlog [16], alog [16], wlog [16];
    int cn, dn, an, wn;
    logic log_en = 1'b0;
    logic [7:0] last_pc, last_pd;
    logic prev_a, prev_d;
    int extra_done;

    always #10 clk = ~clk;

    ppide_reg_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
        .ctl_sel(ctl_sel), .reg_idx(reg_idx), .mode(mode), .wr_val(wr_val),
        .hold(hold), .stat_in(stat_in), .aux_in(aux_in), .pd_in(pd_in),
        .pd_out(pd_out), .pd_oe(pd_oe), .pc_out(pc_out), .epp_astb(epp_astb),
        .epp_dstb(epp_dstb), .epp_wr(epp_wr), .busy(busy), .done(done),
        .err(err), .rd_data(rd_data)
    );

    // Model peripheral: payload bits mixed with junk bits.
    always_comb begin
        stat_in = 8'h00;
        aux_in  = 8'h00;
        pd_in   = 8'hEE;
        case (resp_kind)
            0: stat_in = (pc_out == 8'h03) ? {resp_byte[3:0], 4'h9} : {resp_byte[7:4], 4'h6};
            1: begin
                stat_in = {resp_byte[4:0], 3'b010};
                aux_in  = {4'b1010, resp_byte[7:5], 1'b0};
            end
            2: pd_in = (pc_out == 8'h23) ? resp_byte : 8'h00;
            default: pd_in = (epp_dstb && !epp_wr) ? resp_byte : 8'hEE;
        endcase
    end

    // Line activity log.
    always @(negedge clk) begin
        if (log_en) begin
            if (pc_out != last_pc && cn < 16) begin clog[cn] = pc_out; cn++; end
            if (pd_out != last_pd && dn < 16) begin dlog[dn] = pd_out; dn++; end
            if (epp_astb && !prev_a && an < 16) begin alog[an] = pd_out; an++; end
            if (epp_dstb && epp_wr && !prev_d && wn < 16) begin wlog[wn] = pd_out; wn++; end
        end
        last_pc = pc_out;
        last_pd = pd_out;
        prev_a  = epp_astb;
        prev_d  = epp_dstb;
    end

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic chk_log(input string req, input int n, input int got_n,
                           input logic [7:0] g [16], input logic [7:0] e0,
                           input logic [7:0] e1, input logic [7:0] e2, input logic [7:0] e3);
        logic [7:0] e [4];
        e = '{e0, e1, e2, e3};
        chk({req, " count"}, got_n, n);
        for (int k = 0; k < n && k < got_n; k++) chk({req, " entry"}, g[k], e[k]);
    endtask

    task automatic run_op(input logic wr, input logic cs, input logic [6:0] idx,
                          input logic [2:0] md, input logic [7:0] val, input logic [7:0] hl,
                          output int cyc);
        @(negedge clk);
        cn = 0; dn = 0; an = 0; wn = 0;
        last_pc = pc_out; last_pd = pd_out;
        log_en = 1'b1;
        is_write = wr; ctl_sel = cs; reg_idx = idx; mode = md; wr_val = val; hold = hl;
        start = 1'b1;
        cyc = 0;
        do begin
            @(posedge clk); #1;
            cyc++;
            if (cyc == 1) start = 1'b0;
        end while (!done && cyc < 1000);
        if (cyc >= 1000) chk("done timeout", 0, 1);
        @(negedge clk);
        log_en = 1'b0;
    endtask

    task automatic t_reset;
        chk("R11 pc_out", pc_out, 8'h04);
        chk("R11 pd_out", pd_out, 8'h00);
        chk("R11 strobes", {epp_astb, epp_dstb}, 0);
        chk("R11 busy/done", {busy, done}, 0);
    endtask

    task automatic t_mode0_read;
        int c;
        resp_kind = 0; resp_byte = 8'hC5;
        run_op(1'b0, 1'b1, 7'h02, 3'd0, 8'h00, 8'd0, c);
        chk("R2 read byte", rd_data, 8'hC5);
        chk("R2 err", err, 0);
        chk_log("R1 R2 data", 1, dn, dlog, 8'hBB, 0, 0, 0);
        chk_log("R2 ctrl", 4, cn, clog, 8'h01, 8'h03, 8'h01, 8'h04);
    endtask

    task automatic t_mode1_read;
        int c;
        resp_kind = 1; resp_byte = 8'h6E;
        run_op(1'b0, 1'b0, 7'h0A, 3'd1, 8'h00, 8'd1, c);
        chk("R3 read byte", rd_data, 8'h6E);
        chk_log("R3 data", 3, dn, dlog, 8'h3B, 8'h33, 8'hFB, 0);
        chk_log("R3 ctrl", 4, cn, clog, 8'h01, 8'h03, 8'h05, 8'h04);
    endtask

    task automatic t_mode2_read;
        int c;
        resp_kind = 2; resp_byte = 8'hA7;
        run_op(1'b0, 1'b0, 7'h07, 3'd2, 8'h00, 8'd0, c);
        chk("R4 read byte", rd_data, 8'hA7);
        chk_log("R4 data", 1, dn, dlog, 8'h2E, 0, 0, 0);
        chk_log("R4 ctrl", 4, cn, clog, 8'h01, 8'h21, 8'h23, 8'h04);
        chk("R4 drive back on", pd_oe, 1);
    endtask

    task automatic t_epp_read;
        int c;
        resp_kind = 3; resp_byte = 8'h3C;
        run_op(1'b0, 1'b1, 7'h06, 3'd3, 8'h00, 8'd0, c);
        chk("R6 read byte mode3", rd_data, 8'h3C);
        chk_log("R1 R6 addr", 1, an, alog, 8'h86, 0, 0, 0);
        chk_log("R6 ctrl", 2, cn, clog, 8'h24, 8'h04, 0, 0);
        resp_byte = 8'h81;
        run_op(1'b0, 1'b0, 7'h01, 3'd4, 8'h00, 8'd2, c);
        chk("R6 read byte mode4", rd_data, 8'h81);
        chk_log("R6 addr mode4", 1, an, alog, 8'h01, 0, 0, 0);
    endtask

    task automatic t_epp_write;
        int c;
        resp_kind = 3;
        run_op(1'b1, 1'b0, 7'h02, 3'd5, 8'h9D, 8'd0, c);
        chk_log("R7 addr", 1, an, alog, 8'h42, 0, 0, 0);
        chk_log("R7 data phase", 1, wn, wlog, 8'h9D, 0, 0, 0);
        chk("R7 ctrl quiet", cn, 0);
        chk("R8 cycles epp write", c, 4);
    endtask

    task automatic t_narrow_write;
        int c;
        run_op(1'b1, 1'b1, 7'h07, 3'd2, 8'h5A, 8'd0, c);
        chk_log("R5 data", 2, dn, dlog, 8'h9E, 8'h5A, 0, 0);
        chk_log("R5 ctrl", 3, cn, clog, 8'h01, 8'h03, 8'h04, 0);
        chk("R8 cycles hold0", c, 7);
        run_op(1'b1, 1'b0, 7'h15, 3'd1, 8'h66, 8'd3, c);
        chk("R8 cycles hold3", c, 22);
        chk_log("R5 data mode1", 2, dn, dlog, 8'h0C, 8'h66, 0, 0);
    endtask

    task automatic t_bad_mode;
        int c;
        run_op(1'b0, 1'b0, 7'h03, 3'd6, 8'h00, 8'd5, c);
        chk("R9 cycles", c, 2);
        chk("R9 err", err, 1);
        chk("R9 rd_data", rd_data, 8'hFF);
        chk("R9 no line change", cn + dn + an + wn, 0);
        run_op(1'b1, 1'b0, 7'h03, 3'd7, 8'h12, 8'd0, c);
        chk("R9 mode7 err", err, 1);
    endtask

    task automatic t_busy_ignore;
        int c;
        extra_done = 0;
        fork
            run_op(1'b1, 1'b0, 7'h11, 3'd0, 8'h33, 8'd2, c);
            begin
                repeat (5) @(negedge clk);
                mode = 3'd6; reg_idx = 7'h55; is_write = 1'b0; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        chk("R10 cycles", c, 17);
        chk("R10 err", err, 0);
        chk_log("R10 data", 2, dn, dlog, 8'h08, 8'h33, 0, 0);
        repeat (6) begin
            @(posedge clk); #1;
            if (done) extra_done++;
        end
        chk("R10 single done", extra_done, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_mode0_read();
        t_mode1_read();
        t_mode2_read();
        t_epp_read();
        t_epp_write();
        t_narrow_write();
        t_bad_mode();
        t_busy_ignore();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: got hang expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule